// File: doc/BRIEF.md
# Receive Frame Error Classifier

This block sits beside the receive client path of an Ethernet MAC. It watches a wide, packet-framed streaming bus and sees each received frame as a series of beats marked by start, end and valid. It adds up the frame's byte count across beats, using the empty-byte count on the last beat. It also collects per-frame events that the line decoder raises: a control character that is not a terminate, a failed frame check, and an Error character. It captures the length/type field on the first beat.

On the cycle after the final beat it presents a six-bit error vector. The bits follow a fixed priority. A malformed frame hides the size and length errors. A short frame always carries the check error as well. The payload-length test is skipped for frames outside the legal size range. Frames of eight bytes or fewer are not frames and give no report. The maximum frame size is an input, so it can be changed between frames.

Top module: `rx_frame_err_classifier`

## Requirements
- R1: The frame size is the sum of DATA_BYTES for each valid beat before the last, plus DATA_BYTES minus `in_empty` on the valid beat with `in_eop`. Beats with `in_valid` low add no bytes and their events are ignored, even inside a frame.
- R2: Bit 0 of `err_vec` is set when `ev_ctrl_char` was high on any valid beat of the frame.
- R3: Bit 1 is set when `ev_crc_bad` or `ev_error_char` was high on any valid beat of the frame.
- R4: Bit 2 is set for a frame of 9 to 63 bytes inclusive, and bit 1 is then also set.
- R5: A frame of 8 bytes or fewer gives no report: `err_valid` stays low and `err_vec` stays zero.
- R6: Bit 3 is set when the frame size exceeds `max_frame_bytes`. A frame of exactly that size is not flagged.
- R7: Bit 4 is set when the payload (frame size minus 18 bytes of header and check sequence) is shorter than the length/type field sampled on the first beat, and only when that field is below 1536.
- R8: When bit 0 is set, bits 2, 3 and 4 are zero. When bit 2 or bit 3 is set, bit 4 is zero.
- R9: `err_valid` is high for exactly one cycle, the cycle after the valid `in_eop` beat of a frame of 9 bytes or more. `err_vec` is zero in all other cycles, and bit 5 is always zero.
- R10: All per-frame state restarts on a valid `in_sop` beat, so a frame that follows another with no idle cycle inherits no flags, bytes or length field.
- R11: During and right after reset, `err_valid` and `err_vec` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_empty | input | EMPTY_W | Unused bytes on the last beat |
| ev_ctrl_char | input | 1 | Non-terminate control character seen on this beat |
| ev_crc_bad | input | 1 | Frame check failure reported on this beat |
| ev_error_char | input | 1 | Error character seen on this beat |
| len_type | input | LEN_W | Parsed length/type field, valid on the first beat |
| max_frame_bytes | input | CNT_W | Largest legal frame size in bytes |
| err_valid | output | 1 | Error vector is valid this cycle |
| err_vec | output | 6 | Error vector: malformed, check, short, long, length, reserved |

## Verification
The bench sends frames at the size edges: 8 and 9 bytes, 63 and 64 bytes, and the maximum size and one byte more. A counter that is off by one at any of these edges reports the wrong bit, or reports a runt. It places a malformed event in frames that are also short or long, and places a too-large length field in oversized frames. A design that gets the masking priority wrong then shows extra size or length bits. Idle beats inside a frame carry false events and a false empty count, which a design that ignores `in_valid` picks up. Back-to-back frames, one malformed and the next clean, expose flags that do not clear on the start beat.

// File: rtl/rfe_pkg.sv
// Shared constants and types for the receive frame error classifier.
// Assumes the error vector layout below is decoded by downstream logic.
package rfe_pkg;
    localparam int ERR_W       = 6;
    localparam int BIT_MALFORM = 0;
    localparam int BIT_CHECK   = 1;
    localparam int BIT_SHORT   = 2;
    localparam int BIT_LONG    = 3;
    localparam int BIT_LENGTH  = 4;
    localparam int BIT_RSVD    = 5;

    // Per-frame events accumulated up to and including the current beat.
    typedef struct packed {
        logic malformed;
        logic check_bad;
    } rfe_events_t;
endpackage

// File: rtl/rfe_byte_counter.sv
// Counts frame bytes across beats. The output total includes the present
// beat, so on the last beat it is the full frame size. Assumes in_empty is
// below DATA_BYTES. The sum saturates at the counter's top value.
module rfe_byte_counter #(
    parameter int DATA_BYTES = 64,
    parameter int EMPTY_W    = 6,
    parameter int CNT_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    output logic [CNT_W-1:0]   total
);
    localparam logic [CNT_W-1:0] FULL_BEAT = CNT_W'(DATA_BYTES);

    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] beat_bytes;
    logic [CNT_W:0]   sum;

    // Running size of the frame including this beat.
    always_comb begin
        base       = in_sop ? '0 : acc_q;
        beat_bytes = in_eop ? (FULL_BEAT - CNT_W'(in_empty)) : FULL_BEAT;
        sum        = {1'b0, base} + {1'b0, beat_bytes};
        total      = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end

    // Hold the running size between valid beats.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (in_valid) acc_q <= total;
    end
endmodule

// File: rtl/rfe_event_latch.sv
// Collects decoder events and the length/type field over one frame.
// Outputs reflect all valid beats so far, including the present one.
// A valid start beat discards the previous frame's state.
module rfe_event_latch
    import rfe_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             ev_ctrl_char,
    input  logic             ev_crc_bad,
    input  logic             ev_error_char,
    input  logic [LEN_W-1:0] len_type,
    output rfe_events_t      events,
    output logic [LEN_W-1:0] frame_len
);
    rfe_events_t      ev_q;
    logic [LEN_W-1:0] len_q;

    // Merge stored events with the present beat's events.
    always_comb begin
        events.malformed = (!in_sop && ev_q.malformed) || (in_valid && ev_ctrl_char);
        events.check_bad = (!in_sop && ev_q.check_bad) ||
                           (in_valid && (ev_crc_bad || ev_error_char));
        frame_len        = in_sop ? len_type : len_q;
    end

    // Store events and the first-beat length field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q  <= '0;
            len_q <= '0;
        end else if (in_valid) begin
            ev_q <= events;
            if (in_sop) len_q <= len_type;
        end
    end
endmodule

// File: rtl/rfe_err_resolve.sv
// Turns the frame size, events and length field into the error vector.
// Applies the masking priority and registers the result for one cycle.
// Assumes 'fire' is high only on a valid last beat.
module rfe_err_resolve
    import rfe_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int LEN_W       = 16,
    parameter int RUNT_MAX    = 8,
    parameter int MIN_FRAME   = 64,
    parameter int OVERHEAD    = 18,
    parameter int TYPE_SPLIT  = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] max_frame,
    input  rfe_events_t      events,
    input  logic [LEN_W-1:0] frame_len,
    output logic             err_valid,
    output logic [ERR_W-1:0] err_vec
);
    localparam int CMP_W = (CNT_W > LEN_W) ? CNT_W : LEN_W;
    localparam logic [CNT_W-1:0] RUNT_C  = CNT_W'(RUNT_MAX);
    localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_FRAME);
    localparam logic [CNT_W-1:0] OVER_C  = CNT_W'(OVERHEAD);
    localparam logic [CMP_W-1:0] SPLIT_C = CMP_W'(TYPE_SPLIT);

    logic             is_frame;
    logic             short_f;
    logic             long_f;
    logic             len_f;
    logic [CNT_W-1:0] payload;
    logic [ERR_W-1:0] vec_d;

    // Decide each error bit, then apply the masking order.
    always_comb begin
        is_frame = total > RUNT_C;
        payload  = (total > OVER_C) ? (total - OVER_C) : '0;
        short_f  = !events.malformed && (total < MIN_C);
        long_f   = !events.malformed && (total > max_frame);
        len_f    = !events.malformed && !short_f && !long_f &&
                   (CMP_W'(frame_len) < SPLIT_C) &&
                   (CMP_W'(payload) < CMP_W'(frame_len));
        vec_d              = '0;
        vec_d[BIT_MALFORM] = events.malformed;
        vec_d[BIT_CHECK]   = events.check_bad || short_f;
        vec_d[BIT_SHORT]   = short_f;
        vec_d[BIT_LONG]    = long_f;
        vec_d[BIT_LENGTH]  = len_f;
        vec_d[BIT_RSVD]    = 1'b0;
    end

    // Present the vector for one cycle after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_vec   <= '0;
        end else if (fire && is_frame) begin
            err_valid <= 1'b1;
            err_vec   <= vec_d;
        end else begin
            err_valid <= 1'b0;
            err_vec   <= '0;
        end
    end
endmodule

// File: rtl/rx_frame_err_classifier.sv
// Top of the receive frame error classifier. Counts frame bytes, gathers
// decoder events, and reports a prioritised error vector one cycle after
// each frame's last beat. Assumes in_sop/in_eop are meaningful only with
// in_valid, and len_type is valid on the first beat.
module rx_frame_err_classifier
    import rfe_pkg::*;
#(
    parameter int DATA_BYTES = 64,
    parameter int EMPTY_W    = $clog2(DATA_BYTES),
    parameter int CNT_W      = 16,
    parameter int LEN_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    input  logic               ev_ctrl_char,
    input  logic               ev_crc_bad,
    input  logic               ev_error_char,
    input  logic [LEN_W-1:0]   len_type,
    input  logic [CNT_W-1:0]   max_frame_bytes,
    output logic               err_valid,
    output logic [ERR_W-1:0]   err_vec
);
    logic [CNT_W-1:0] total;
    rfe_events_t      events;
    logic [LEN_W-1:0] frame_len;
    logic             fire;

    // Last valid beat of a frame.
    always_comb fire = in_valid && in_eop;

    rfe_byte_counter #(
        .DATA_BYTES(DATA_BYTES),
        .EMPTY_W   (EMPTY_W),
        .CNT_W     (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_sop  (in_sop),
        .in_eop  (in_eop),
        .in_empty(in_empty),
        .total   (total)
    );

    rfe_event_latch #(
        .LEN_W(LEN_W)
    ) u_events (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sop       (in_sop),
        .ev_ctrl_char (ev_ctrl_char),
        .ev_crc_bad   (ev_crc_bad),
        .ev_error_char(ev_error_char),
        .len_type     (len_type),
        .events       (events),
        .frame_len    (frame_len)
    );

    rfe_err_resolve #(
        .CNT_W(CNT_W),
        .LEN_W(LEN_W)
    ) u_resolve (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .total    (total),
        .max_frame(max_frame_bytes),
        .events   (events),
        .frame_len(frame_len),
        .err_valid(err_valid),
        .err_vec  (err_vec)
    );
endmodule

// File: rtl/rfe_checker.sv
// Property checker for the classifier's output vector and report timing.
module rfe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_eop,
    input logic       err_valid,
    input logic [5:0] err_vec
);
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> (err_vec == 6'd0)); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vec[5]); // R9
    AST_SHORT_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        err_vec[2] |-> err_vec[1]); // R4
    AST_MAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        err_vec[0] |-> (err_vec[4:2] == 3'd0)); // R8
    AST_SIZE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vec[2] || err_vec[3]) |-> !err_vec[4]); // R8
    AST_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_eop) |=> !err_valid); // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !(in_valid && in_eop)) |=> !err_valid); // R9
endmodule

bind rx_frame_err_classifier rfe_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_eop   (in_eop),
    .err_valid(err_valid),
    .err_vec  (err_vec)
);

// File: tb/sim_rx_frame_err_classifier.sv
module sim_rx_frame_err_classifier;
    localparam int DB = 16;
    localparam int EW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [EW-1:0] in_empty = '0;
    logic          ev_ctrl_char = 1'b0, ev_crc_bad = 1'b0, ev_error_char = 1'b0;
    logic [15:0]   len_type = '0;
    logic [15:0]   max_frame_bytes = 16'd1518;
    logic          err_valid;
    logic [5:0]    err_vec;

    int    checks = 0, errors = 0, cyc = 0;
    logic  nxt_valid = 1'b0;
    logic [5:0] nxt_vec = '0;
    string tag = "R11";

    always #5 clk = ~clk;

    rx_frame_err_classifier #(.DATA_BYTES(DB), .CNT_W(16), .LEN_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_empty(in_empty), .ev_ctrl_char(ev_ctrl_char),
        .ev_crc_bad(ev_crc_bad), .ev_error_char(ev_error_char),
        .len_type(len_type), .max_frame_bytes(max_frame_bytes),
        .err_valid(err_valid), .err_vec(err_vec)
    );

    // Reference: expected report for a whole frame, from the requirements.
    function automatic logic [6:0] model(int n, bit mal, bit bad, int lenf, int maxf);
        logic [5:0] v = '0;
        if (n <= 8) return 7'd0;                        // R5
        v[0] = mal;                                      // R2
        v[1] = bad;                                      // R3
        if (!mal) begin
            if (n < 64) begin v[2] = 1'b1; v[1] = 1'b1; end  // R4
            if (n > maxf) v[3] = 1'b1;                   // R6
            if (v[2] == 1'b0 && v[3] == 1'b0 && lenf < 1536 && (n - 18) < lenf)
                v[4] = 1'b1;                             // R7, R8
        end
        return {1'b1, v};
    endfunction

    // Compare against the reference after every rising edge.
    always @(posedge clk) begin
        #2;
        checks++;
        if (err_valid !== nxt_valid || err_vec !== nxt_vec) begin
            errors++;
            $display("FAIL %s: got valid=%b vec=%h expected valid=%b vec=%h",
                     tag, err_valid, err_vec, nxt_valid, nxt_vec);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
            ev_ctrl_char = 1'b0; ev_crc_bad = 1'b0; ev_error_char = 1'b0;
            nxt_valid = 1'b0; nxt_vec = '0;
        end
    endtask

    // Send one frame of n bytes. ctl_beat/err_beat: beat carrying that event
    // (-1 none). gap_beat: an idle beat with false events inserted before it.
    task automatic send(string t, int n, int ctl_beat, bit crc_bad, int err_beat,
                        int lenf, int gap_beat);
        int beats = (n + DB - 1) / DB;
        logic [6:0] exp = model(n, ctl_beat >= 0 && ctl_beat < beats,
                                crc_bad || (err_beat >= 0 && err_beat < beats),
                                lenf, int'(max_frame_bytes));
        tag = t;
        for (int b = 0; b < beats; b++) begin
            if (b == gap_beat && b > 0) begin
                @(negedge clk);
                in_valid = 1'b0; in_sop = 1'b1; in_eop = 1'b1;
                in_empty = '1; ev_ctrl_char = 1'b1; ev_crc_bad = 1'b1;
                ev_error_char = 1'b1; len_type = 16'd9000;
                nxt_valid = 1'b0; nxt_vec = '0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sop = (b == 0);
            in_eop = (b == beats - 1);
            in_empty = (b == beats - 1) ? EW'(beats * DB - n) : EW'(5);
            ev_ctrl_char = (b == ctl_beat);
            ev_crc_bad = crc_bad && (b == beats - 1);
            ev_error_char = (b == err_beat);
            len_type = (b == 0) ? 16'(lenf) : 16'hFFFF;
            nxt_valid = (b == beats - 1) ? exp[6] : 1'b0;
            nxt_vec = (b == beats - 1) ? exp[5:0] : 6'd0;
        end
    endtask

    initial begin
        tag = "R11";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // Sizes and length field (R1, R7)
        send("R7 len equal payload", 64, -1, 0, -1, 46, -1); idle(1);
        send("R7 len above payload", 64, -1, 0, -1, 47, -1); idle(1);
        send("R7 type value 1536", 64, -1, 0, -1, 1536, -1); idle(1);
        send("R7 len 1535", 200, -1, 0, -1, 1535, -1); idle(1);
        send("R1 multi-beat odd size", 333, -1, 0, -1, 100, -1); idle(1);
        // Short frames and runts (R4, R5)
        send("R4 63 bytes", 63, -1, 0, -1, 40, -1); idle(1);
        send("R4 9 bytes", 9, -1, 0, -1, 0, -1); idle(1);
        send("R5 8 bytes", 8, -1, 0, -1, 0, -1); idle(1);
        send("R5 1 byte with events", 1, 0, 1, 0, 0, -1); idle(1);
        // Check failures (R3)
        send("R3 crc fail", 100, -1, 1, -1, 46, -1); idle(1);
        send("R3 error char", 100, -1, 0, 2, 46, -1); idle(1);
        // Oversize (R6, R8)
        send("R6 at max", 1518, -1, 0, -1, 1500, -1); idle(1);
        send("R6 above max", 1519, -1, 0, -1, 1500, -1); idle(1);
        send("R8 long masks length", 1519, -1, 0, -1, 1535, -1); idle(1);
        send("R8 short masks length", 40, -1, 0, -1, 1000, -1); idle(1);
        // Malformed (R2, R8)
        send("R2 malformed", 100, 3, 0, -1, 46, -1); idle(1);
        send("R8 malformed short", 30, 0, 0, -1, 1000, -1); idle(1);
        send("R8 malformed long", 1600, 50, 0, -1, 1535, -1); idle(1);
        send("R2 malformed with crc", 80, 1, 1, -1, 46, -1); idle(1);
        // Idle beats inside a frame (R1)
        send("R1 gap with false events", 100, -1, 0, -1, 46, 3); idle(1);
        send("R1 gap in short frame", 40, -1, 0, -1, 10, 2); idle(1);
        // Back-to-back frames (R10)
        send("R10 bad frame first", 70, 1, 1, -1, 1400, -1);
        send("R10 clean after bad", 64, -1, 0, -1, 46, -1);
        send("R10 short after clean", 20, -1, 0, -1, 0, -1);
        send("R10 single beat after short", 16, -1, 0, -1, 0, -1);
        send("R10 clean after short", 65, -1, 0, -1, 47, -1); idle(2);
        // Programmable maximum (R6)
        max_frame_bytes = 16'd100;
        send("R6 max 100 at", 100, -1, 0, -1, 46, -1); idle(1);
        send("R6 max 100 above", 101, -1, 0, -1, 46, -1); idle(3);
        tag = "R9";
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule